// File: doc/BRIEF.md
# Slave Read Transaction Responder

This block sits on the display side of a serial link and answers read requests from a host. It watches an idle-high serial input for a start bit and shifts in one control word. The word carries six control bits, a read/write flag and a strobe-source select bit. Every received word is presented on the control outputs.

When the flag marks a read, the block takes over the rest of the exchange. It stops driving the 18-bit display data port and produces a low-going write-clock pulse. The display places its data on the bus after the falling edge. The block samples the bus on the rising edge of that pulse. It then turns the link around and sends the 18 data bits back to the host in a start-bit framed word. While this exchange is in progress, the serial input is not listened to. A word that is not a read only updates the control outputs.

Top module: `readResponder`

## Requirements
- R1: During and right after reset, `ctrlOut` and `selOut` are 0, and `wrClk`, `linkOut` and `dataOe` are 1.
- R2: An inbound frame is a 0 start bit on the otherwise-high `linkIn`, followed by 8 bits, one per clock, least significant first. Word bits 5:0 are the control bits, bit 6 is the read flag (1 = read) and bit 7 is the select bit. `ctrlOut` and `selOut` take the new values on the clock edge that samples the last bit. While `linkIn` stays high, no frame starts and the outputs hold.
- R3: For a read word, `dataOe` falls on the same edge that updates `ctrlOut`.
- R4: `wrClk` falls one clock after that edge, and `dataOe` is already 0 when it falls.
- R5: `wrClk` stays low for exactly `WCLK_LOW` clocks (default 4) and then rises.
- R6: The value returned is the `dataIn` value present in the clock before `wrClk` rises. Changes to `dataIn` after the rise do not affect it.
- R7: On the edge where `wrClk` rises, `linkOut` drives a 0 start bit. The 18 data bits follow, one per clock, least significant first.
- R8: One clock after the last data bit, `linkOut` returns high and `dataOe` returns to 1 on the same edge.
- R9: A word with the read flag at 0 produces no `wrClk` pulse and no return frame, and `dataOe` stays 1.
- R10: From the end of a read word until the end of its return frame, `linkIn` is ignored. Start-bit patterns in that window neither change `ctrlOut` nor start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linkIn | input | 1 | Inbound serial line, idle high |
| linkOut | output | 1 | Return serial line, idle high |
| ctrlOut | output | 6 | Control bits of the last received word |
| selOut | output | 1 | Select bit of the last received word |
| dataIn | input | 18 | Display data bus as seen by the block |
| dataOe | output | 1 | 1 while the block drives the data port, 0 while the port is an input |
| wrClk | output | 1 | Write-clock pulse toward the display, idle high |

## Verification
Read exchanges are run with several data words: a mixed pattern, all ones, a lone low bit and a lone high bit. Together these separate a wrong bit order, a stuck or missing bit and a shifted frame in the return word. The bench changes the bus right after the write-clock rises. This tells sampling at the rise apart from sampling later. Non-read words, placed both before and after reads, show that the pulse and the return frame depend on the flag alone. A read whose turnaround window is filled with start-bit patterns on the input shows that the receiver stays deaf during the exchange.

// File: rtl/rdrPkg.sv
package rdrPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_TURN,
    S_LOW,
    S_SEND
  } rspState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic rxShift;
    logic wordLoad;
    logic oeOff;
    logic wclkFall;
    logic wclkRise;
    logic txLoad;
    logic txShift;
    logic txEnd;
  } pathStrobe_t;

endpackage

// File: rtl/rdrCtrl.sv
module rdrCtrl
  import rdrPkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int DATA_W   = 18,
  parameter int WCLK_LOW = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkIn,
  input  logic        isRead,
  output pathStrobe_t strb
);

  localparam int MAX_A = (WORD_W > DATA_W + 1) ? WORD_W : DATA_W + 1;
  localparam int MAX_C = (MAX_A > WCLK_LOW) ? MAX_A : WCLK_LOW;
  localparam int CNT_W = $clog2(MAX_C + 1);

  rspState_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    nextCnt   = cnt;
    case (state)
      S_IDLE: begin
        if (!linkIn) begin
          nextState = S_RECV;
          nextCnt   = '0;
        end
      end
      S_RECV: begin
        strb.rxShift = 1'b1;
        if (cnt == CNT_W'(WORD_W - 1)) begin
          strb.wordLoad = 1'b1;
          nextCnt       = '0;
          if (isRead) begin
            strb.oeOff = 1'b1;
            nextState  = S_TURN;
          end else begin
            nextState = S_IDLE;
          end
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      S_TURN: begin
        strb.wclkFall = 1'b1;
        nextState     = S_LOW;
        nextCnt       = '0;
      end
      S_LOW: begin
        if (cnt == CNT_W'(WCLK_LOW - 1)) begin
          strb.wclkRise = 1'b1;
          strb.txLoad   = 1'b1;
          nextState     = S_SEND;
          nextCnt       = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      S_SEND: begin
        if (cnt == CNT_W'(DATA_W)) begin
          strb.txEnd = 1'b1;
          nextState  = S_IDLE;
          nextCnt    = '0;
        end else begin
          strb.txShift = 1'b1;
          nextCnt      = cnt + 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // receiving and the return exchange never overlap
  p_phase_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rxShift, strb.wclkFall, strb.wclkRise, strb.txShift, strb.txEnd}));

  // a non-read word returns straight to idle
  p_write_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordLoad && !strb.oeOff) |=> (state == S_IDLE));

endmodule

// File: rtl/rdrPath.sv
module rdrPath
  import rdrPkg::*;
#(
  parameter int CTRL_W   = 6,
  parameter int DATA_W   = 18,
  parameter int WCLK_LOW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkIn,
  input  pathStrobe_t       strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              isRead,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              selOut,
  output logic              dataOe,
  output logic              wrClk,
  output logic              linkOut
);

  localparam int WORD_W = CTRL_W + 2;
  localparam int LOW_W  = $clog2(WCLK_LOW + 2);

  logic [WORD_W-2:0] rxSr;
  logic [WORD_W-1:0] rxWord;
  logic [DATA_W-1:0] txSr;

  assign rxWord = {linkIn, rxSr};
  assign isRead = rxWord[CTRL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr    <= '0;
      ctrlOut <= '0;
      selOut  <= 1'b0;
    end else begin
      if (strb.rxShift) rxSr <= rxWord[WORD_W-1:1];
      if (strb.wordLoad) begin
        ctrlOut <= rxWord[CTRL_W-1:0];
        selOut  <= rxWord[WORD_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOe <= 1'b1;
      wrClk  <= 1'b1;
    end else begin
      if (strb.oeOff) dataOe <= 1'b0;
      else if (strb.txEnd) dataOe <= 1'b1;
      if (strb.wclkFall) wrClk <= 1'b0;
      else if (strb.wclkRise) wrClk <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr    <= '0;
      linkOut <= 1'b1;
    end else begin
      if (strb.txLoad) begin
        txSr    <= dataIn;
        linkOut <= 1'b0;
      end else if (strb.txShift) begin
        txSr    <= {1'b0, txSr[DATA_W-1:1]};
        linkOut <= txSr[0];
      end else if (strb.txEnd) begin
        linkOut <= 1'b1;
      end
    end
  end

  // checker counter: length of the write-clock low phase
  logic [LOW_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (!wrClk) lowCnt <= lowCnt + 1'b1;
    else lowCnt <= '0;
  end

  p_oe_before_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrClk) |-> !dataOe);

  p_low_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrClk) |-> (lowCnt == LOW_W'(WCLK_LOW)));

  p_start_on_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrClk) |-> !linkOut);

  p_oe_back_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> (linkOut && wrClk));

  p_quiet_link_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (linkOut && wrClk));

endmodule

// File: rtl/readResponder.sv
module readResponder
  import rdrPkg::*;
#(
  parameter int CTRL_W   = 6,
  parameter int DATA_W   = 18,
  parameter int WCLK_LOW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkIn,
  output logic              linkOut,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              selOut,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataOe,
  output logic              wrClk
);

  localparam int WORD_W = CTRL_W + 2;

  pathStrobe_t strb;
  logic        isRead;

  rdrCtrl #(
    .WORD_W  (WORD_W),
    .DATA_W  (DATA_W),
    .WCLK_LOW(WCLK_LOW)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .linkIn(linkIn),
    .isRead(isRead),
    .strb  (strb)
  );

  rdrPath #(
    .CTRL_W  (CTRL_W),
    .DATA_W  (DATA_W),
    .WCLK_LOW(WCLK_LOW)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .linkIn (linkIn),
    .strb   (strb),
    .dataIn (dataIn),
    .isRead (isRead),
    .ctrlOut(ctrlOut),
    .selOut (selOut),
    .dataOe (dataOe),
    .wrClk  (wrClk),
    .linkOut(linkOut)
  );

endmodule

// File: tb/readResponder_test.sv
module readResponder_test;

  localparam int CTRL_W   = 6;
  localparam int DATA_W   = 18;
  localparam int WCLK_LOW = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              linkIn = 1'b1;
  logic              linkOut;
  logic [CTRL_W-1:0] ctrlOut;
  logic              selOut;
  logic [DATA_W-1:0] dataIn = '0;
  logic              dataOe;
  logic              wrClk;

  int  vecCount = 0;
  int  badCount = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  readResponder #(
    .CTRL_W(CTRL_W), .DATA_W(DATA_W), .WCLK_LOW(WCLK_LOW)
  ) uut (
    .clk(clk), .rstN(rstN), .linkIn(linkIn), .linkOut(linkOut),
    .ctrlOut(ctrlOut), .selOut(selOut), .dataIn(dataIn),
    .dataOe(dataOe), .wrClk(wrClk)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      badCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one inbound frame; returns at the negedge after the last-bit edge
  task automatic sendWord(input logic [5:0] c, input logic rw, input logic s);
    logic [7:0] w;
    w = {s, rw, c};
    @(negedge clk) linkIn = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) linkIn = w[k];
    end
    @(negedge clk) linkIn = 1'b1;
  endtask

  task automatic writeCase(input logic [5:0] c, input logic s);
    bit quiet;
    sendWord(c, 1'b0, s);
    check(ctrlOut == c, "R2 ctrl", 32'(ctrlOut), 32'(c));
    check(selOut == s, "R2 sel", 32'(selOut), 32'(s));
    check(dataOe == 1'b1, "R9 oe", 32'(dataOe), 32'd1);
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!wrClk || !linkOut || !dataOe) quiet = 1'b0;
    end
    check(quiet, "R9 no pulse/frame", 32'(quiet), 32'd1);
  endtask

  task automatic readCase(input logic [5:0] c, input logic s,
                          input logic [DATA_W-1:0] d, input bit noise);
    logic [DATA_W-1:0] got;
    sendWord(c, 1'b1, s);
    check(ctrlOut == c, "R2 ctrl", 32'(ctrlOut), 32'(c));
    check(selOut == s, "R2 sel", 32'(selOut), 32'(s));
    check(dataOe == 1'b0, "R3 oe off", 32'(dataOe), 32'd0);
    check(wrClk == 1'b1, "R4 not yet", 32'(wrClk), 32'd1);
    @(negedge clk);
    check(wrClk == 1'b0, "R4 fall", 32'(wrClk), 32'd0);
    dataIn = d;
    if (noise) linkIn = 1'b0;
    for (int i = 1; i < WCLK_LOW; i++) begin
      @(negedge clk);
      check(wrClk == 1'b0, "R5 low", 32'(wrClk), 32'd0);
      if (noise) linkIn = i[0];
    end
    @(negedge clk);
    check(wrClk == 1'b1, "R5 rise", 32'(wrClk), 32'd1);
    check(linkOut == 1'b0, "R7 start", 32'(linkOut), 32'd0);
    dataIn = ~d;
    for (int i = 0; i < DATA_W; i++) begin
      @(negedge clk);
      got[i] = linkOut;
      if (noise) linkIn = i[0];
    end
    check(got == d, "R6/R7 data", 32'(got), 32'(d));
    @(negedge clk);
    linkIn = 1'b1;
    check(linkOut == 1'b1, "R8 stop", 32'(linkOut), 32'd1);
    check(dataOe == 1'b1, "R8 oe back", 32'(dataOe), 32'd1);
    for (int i = 0; i < 12; i++) @(negedge clk);
    if (noise) begin
      check(ctrlOut == c, "R10 ctrl held", 32'(ctrlOut), 32'(c));
      check(wrClk && linkOut && dataOe, "R10 no new frame",
            32'({wrClk, linkOut, dataOe}), 32'h7);
    end
  endtask

  task automatic idleCase();
    logic [5:0] c0;
    c0 = ctrlOut;
    linkIn = 1'b1;
    for (int i = 0; i < 20; i++) @(negedge clk);
    check(ctrlOut == c0, "R2 idle hold", 32'(ctrlOut), 32'(c0));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      badCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ctrlOut == '0 && selOut == 1'b0, "R1 ctrl", 32'({selOut, ctrlOut}), 32'd0);
    check(wrClk && linkOut && dataOe, "R1 idle", 32'({wrClk, linkOut, dataOe}), 32'h7);
    rstN = 1'b1;
    @(negedge clk);
    check(wrClk && linkOut && dataOe, "R1 after", 32'({wrClk, linkOut, dataOe}), 32'h7);
    idleCase();
    writeCase(6'h2A, 1'b1);
    readCase(6'h15, 1'b0, 18'h2B3C5, 1'b0);
    readCase(6'h3F, 1'b1, 18'h3FFFF, 1'b1);
    readCase(6'h00, 1'b0, 18'h3FFFE, 1'b0);
    readCase(6'h01, 1'b1, 18'h20000, 1'b0);
    writeCase(6'h13, 1'b0);
    idleCase();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

endmodule